// File: doc/BRIEF.md
# I2C Target Multi-Address Recogniser

This block decides whether an address frame seen by an I2C target belongs to it. A front end that shifts bits in from the bus hands over each received byte with a strobe. It also marks the first byte after a START or repeated START. The recogniser compares that frame against four programmable own addresses. Each own address has its own don't-care mask. The block reports whether any of them matched, which one is the primary match, and the read/write bit of the frame.

The recogniser handles 7-bit and 10-bit addressing. A 10-bit frame is only accepted once both of its address bytes have arrived. When enabled, it also recognises the general call address. Each address slot owns a sticky status flag that records that the slot matched. Software clears a flag by writing 1 to it. Acknowledge generation, bit shifting and wake-up handling sit outside this block.

Top module: `i2c_addr_match`

## Requirements
- R1: While reset is held, and after reset until the first match, match_pulse, match_gc, match_rw, match_slot and slot_flags are all zero.
- R2: In 7-bit mode (mode10=0), a byte with in_vld=1 and in_first=1 is compared as follows. Bits [7:1] of the byte are compared with bits [9:3] of each own address field. On a match, match_pulse is high for exactly the cycle after the strobe, and match_rw equals bit 0 of that byte.
- R3: A mask bit of 1 makes the corresponding address bit don't-care. A mask bit of 0 makes any difference in that bit block the match.
- R4: A slot whose whole 10-bit own address field is zero never matches, whatever its mask.
- R5: With gc_en=1, a first byte equal to 0x00 is reported as a general call: match_pulse and match_gc are high together, match_rw=0, and no slot flag is set. With gc_en=0, or with the first byte equal to 0x01, that byte produces no pulse. A received 7-bit address of zero never produces a slot match.
- R6: In 10-bit mode (mode10=1), the first byte must read 11110 in bits [7:3]. Its bits [2:1] are compared with own address bits [9:8], and its bit 0 is the read/write bit. The next non-first byte is compared with own address bits [7:0]. match_pulse rises only in the cycle after that second byte, never after the header alone. A further non-first byte without a pending header is ignored.
- R7: In 10-bit mode, a first byte that does not start with 11110 produces no match, even if it would match in 7-bit mode.
- R8: When several slots match one frame, all of their flags are set. match_slot reports the lowest-numbered matching slot.
- R9: Each flag in slot_flags stays set until a 1 is written to the same bit of slot_clr. A set from a match in the same cycle as a clear wins.
- R10: In 7-bit mode, a byte with in_first=0 is never treated as an address.
- R11: match_slot and match_rw hold their values between matches. A general call updates match_rw but leaves match_slot unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Received byte strobe |
| in_first | input | 1 | Marks the first byte after START or repeated START |
| in_byte | input | 8 | Received byte |
| mode10 | input | 1 | 1 selects 10-bit address matching |
| gc_en | input | 1 | Enables general call recognition |
| own_addr | input | NSLOT*AW | Own address fields, slot i at bits [i*AW +: AW] |
| own_mask | input | NSLOT*AW | Don't-care masks, same layout as own_addr |
| slot_clr | input | NSLOT | Write-1-to-clear strobes for slot_flags |
| match_pulse | output | 1 | One-cycle pulse on a recognised frame |
| match_slot | output | IW | Lowest matching slot index |
| match_gc | output | 1 | High with match_pulse for a general call |
| match_rw | output | 1 | Read/write bit of the last recognised frame |
| slot_flags | output | NSLOT | Sticky per-slot match flags |

## Verification
The bench builds the block with its default values: four slots and a 10-bit address field. With four slots, one frame can hit two overlapping masked slots, and one slot can hold the unusable all-zero address behind a fully open mask. The 10-bit field width lets the bench check both header bits against the masks, and check the low byte separately after the header.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;
    // Upper five bits of a 10-bit addressing header byte
    localparam logic [4:0] HDR10_TAG = 5'b11110;
    // Byte value that addresses every target (general call)
    localparam logic [7:0] GCALL_BYTE = 8'h00;
    // Width of a 7-bit address carried in bits [7:1] of the first byte
    localparam int unsigned A7W = 7;
endpackage

// File: rtl/am_slot_cmp.sv
module am_slot_cmp #(
    parameter int AW = 10
) (
    input  logic [AW-1:0] addr_i,
    input  logic [AW-1:0] mask_i,
    input  logic [6:0]    rx7_i,
    input  logic [1:0]    hdr_i,
    input  logic [7:0]    lo_i,
    output logic          hit7_o,
    output logic          hit_hi_o,
    output logic          hit_lo_o
);
    localparam int LOW = AW - 2;

    logic live;
    logic [6:0]     diff7;
    logic [1:0]     diff_hi;
    logic [LOW-1:0] diff_lo;

    always_comb begin
        live    = |addr_i;
        diff7   = (rx7_i ^ addr_i[AW-1 -: 7]) & ~mask_i[AW-1 -: 7];
        diff_hi = (hdr_i ^ addr_i[AW-1 -: 2]) & ~mask_i[AW-1 -: 2];
        diff_lo = (lo_i ^ addr_i[LOW-1:0]) & ~mask_i[LOW-1:0];
        hit7_o   = live && (diff7 == '0);
        hit_hi_o = live && (diff_hi == '0);
        hit_lo_o = live && (diff_lo == '0);
    end
endmodule

// File: rtl/am_low_pick.sv
module am_low_pick #(
    parameter int NSLOT = 4,
    parameter int IW    = 2
) (
    input  logic [NSLOT-1:0] req_i,
    output logic [IW-1:0]    idx_o,
    output logic             any_o
);
    always_comb begin
        idx_o = '0;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = IW'(i);
        end
        any_o = |req_i;
    end
endmodule

// File: rtl/am_flag_bank.sv
module am_flag_bank #(
    parameter int NSLOT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSLOT-1:0] set_i,
    input  logic [NSLOT-1:0] clr_i,
    output logic [NSLOT-1:0] flags_o
);
    logic [NSLOT-1:0] flags_d, flags_q;

    always_comb begin
        flags_d = (flags_q & ~clr_i) | set_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags_o = flags_q;
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
    import i2c_am_pkg::*;
#(
    parameter int NSLOT = 4,
    parameter int AW    = 10,
    localparam int IW   = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_vld,
    input  logic                  in_first,
    input  logic [7:0]            in_byte,
    input  logic                  mode10,
    input  logic                  gc_en,
    input  logic [NSLOT*AW-1:0]   own_addr,
    input  logic [NSLOT*AW-1:0]   own_mask,
    input  logic [NSLOT-1:0]      slot_clr,
    output logic                  match_pulse,
    output logic [IW-1:0]         match_slot,
    output logic                  match_gc,
    output logic                  match_rw,
    output logic [NSLOT-1:0]      slot_flags
);
    typedef struct packed {
        logic [NSLOT-1:0] pend;
        logic             pend_rw;
        logic             pulse;
        logic             gc;
        logic [IW-1:0]    slot;
        logic             rw;
    } st_t;

    st_t st_d, st_q;

    logic [NSLOT-1:0] hit7_v, hihit_v, lohit_v;
    logic [NSLOT-1:0] hits;
    logic             gc_now;
    logic [IW-1:0]    pick_idx;
    logic             pick_any;

    // Per-slot comparators
    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        am_slot_cmp #(.AW(AW)) u_cmp (
            .addr_i   (own_addr[g*AW +: AW]),
            .mask_i   (own_mask[g*AW +: AW]),
            .rx7_i    (in_byte[7:1]),
            .hdr_i    (in_byte[2:1]),
            .lo_i     (in_byte),
            .hit7_o   (hit7_v[g]),
            .hit_hi_o (hihit_v[g]),
            .hit_lo_o (lohit_v[g])
        );
    end

    // Frame classification: which slots complete a match this cycle
    always_comb begin
        hits   = '0;
        gc_now = 1'b0;
        if (in_vld) begin
            if (in_first) begin
                if (gc_en && in_byte == GCALL_BYTE) begin
                    gc_now = 1'b1;
                end else if (!mode10 && in_byte[7:1] != '0) begin
                    hits = hit7_v;
                end
            end else begin
                hits = st_q.pend & lohit_v;
            end
        end
    end

    am_low_pick #(.NSLOT(NSLOT), .IW(IW)) u_pick (
        .req_i (hits),
        .idx_o (pick_idx),
        .any_o (pick_any)
    );

    am_flag_bank #(.NSLOT(NSLOT)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (hits),
        .clr_i   (slot_clr),
        .flags_o (slot_flags)
    );

    // Next-state logic
    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        st_d.gc    = 1'b0;
        if (in_vld) begin
            st_d.pend = '0;
            if (in_first && mode10 && !gc_now && in_byte[7:3] == HDR10_TAG) begin
                st_d.pend    = hihit_v;
                st_d.pend_rw = in_byte[0];
            end
            if (gc_now) begin
                st_d.pulse = 1'b1;
                st_d.gc    = 1'b1;
                st_d.rw    = 1'b0;
            end else if (pick_any) begin
                st_d.pulse = 1'b1;
                st_d.slot  = pick_idx;
                st_d.rw    = in_first ? in_byte[0] : st_q.pend_rw;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign match_pulse = st_q.pulse;
    assign match_gc    = st_q.gc;
    assign match_slot  = st_q.slot;
    assign match_rw    = st_q.rw;
endmodule

// File: rtl/i2c_addr_match_chk.sv
module i2c_addr_match_chk #(
    parameter int NSLOT = 4,
    parameter int IW    = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_vld,
    input logic [NSLOT-1:0] slot_clr,
    input logic             match_pulse,
    input logic [IW-1:0]    match_slot,
    input logic             match_gc,
    input logic             match_rw,
    input logic [NSLOT-1:0] slot_flags
);
    // A pulse always follows a received byte (R2)
    p_pulse_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
        match_pulse |-> $past(in_vld));

    // General call indication only ever rides on a pulse (R5)
    p_gc_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        match_gc |-> match_pulse);

    // The reported slot has its flag set on a slot match (R8)
    p_slot_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (match_pulse && !match_gc) |-> slot_flags[match_slot]);

    // Flags only change on a clear or a match (R9)
    p_flag_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_clr == '0) |=> (match_pulse || $stable(slot_flags)));

    // Slot index and R/W bit hold between pulses (R11)
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !match_pulse |-> ($stable(match_slot) && $stable(match_rw)));

    // A general call leaves the slot index unchanged (R11)
    p_gc_slot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        match_gc |-> $stable(match_slot));
endmodule

bind i2c_addr_match i2c_addr_match_chk #(.NSLOT(NSLOT), .IW(IW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_vld      (in_vld),
    .slot_clr    (slot_clr),
    .match_pulse (match_pulse),
    .match_slot  (match_slot),
    .match_gc    (match_gc),
    .match_rw    (match_rw),
    .slot_flags  (slot_flags)
);

// File: tb/sim_i2c_addr_match.sv
module sim_i2c_addr_match;
    localparam int CLK_PER = 10;
    localparam int NSLOT   = 4;
    localparam int AW      = 10;

    logic clk = 1'b0;
    logic rst_n;
    logic in_vld, in_first, mode10, gc_en;
    logic [7:0] in_byte;
    logic [NSLOT*AW-1:0] own_addr, own_mask;
    logic [NSLOT-1:0] slot_clr;
    logic match_pulse, match_gc, match_rw;
    logic [1:0] match_slot;
    logic [NSLOT-1:0] slot_flags;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 0;

    typedef struct {
        int         due;
        logic       pulse;
        logic       gc;
        logic [1:0] slot;
        logic       rw;
        logic [3:0] flags;
        string      tag;
    } exp_t;

    exp_t sbq[$];

    logic [3:0] m_flags = '0;
    logic [1:0] m_slot  = '0;
    logic       m_rw    = 1'b0;

    always #(CLK_PER/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    i2c_addr_match u0 (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_first(in_first),
        .in_byte(in_byte), .mode10(mode10), .gc_en(gc_en),
        .own_addr(own_addr), .own_mask(own_mask), .slot_clr(slot_clr),
        .match_pulse(match_pulse), .match_slot(match_slot), .match_gc(match_gc),
        .match_rw(match_rw), .slot_flags(slot_flags)
    );

    task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    task automatic set_slot(input int i, input logic [AW-1:0] a, input logic [AW-1:0] m);
        own_addr[i*AW +: AW] = a;
        own_mask[i*AW +: AW] = m;
    endtask

    // Driver: called at a negedge, drives one cycle and pushes the expectation
    task automatic send(input bit vld, input bit first, input logic [7:0] b,
                        input logic [3:0] clr, input bit ep, input bit egc,
                        input logic [3:0] eset, input logic [1:0] eslot,
                        input bit erw, input string tag);
        exp_t e;
        m_flags = (m_flags & ~clr) | eset;
        if (ep) begin
            m_rw = erw;
            if (!egc) m_slot = eslot;
        end
        e.due = cyc + 1; e.pulse = ep; e.gc = egc; e.slot = m_slot;
        e.rw = m_rw; e.flags = m_flags; e.tag = tag;
        sbq.push_back(e);
        in_vld = vld; in_first = first; in_byte = b; slot_clr = clr;
        @(negedge clk);
        in_vld = 1'b0; in_first = 1'b0; in_byte = 8'h00; slot_clr = '0;
    endtask

    // Monitor: pops expectations that are due
    always @(negedge clk) begin
        while (sbq.size() > 0 && sbq[0].due <= cyc) begin
            exp_t e;
            e = sbq.pop_front();
            chk(e.tag, "pulse", 8'(match_pulse), 8'(e.pulse));
            chk(e.tag, "gc",    8'(match_gc),    8'(e.gc));
            chk(e.tag, "slot",  8'(match_slot),  8'(e.slot));
            chk(e.tag, "rw",    8'(match_rw),    8'(e.rw));
            chk(e.tag, "flags", 8'(slot_flags),  8'(e.flags));
        end
    end

    initial begin
        #(CLK_PER * 100000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; in_vld = 0; in_first = 0; in_byte = 0;
        mode10 = 0; gc_en = 0; slot_clr = '0; own_addr = '0; own_mask = '0;
        // 7-bit setup
        set_slot(0, 10'(7'h50) << 3, '0);
        set_slot(1, 10'(7'h52) << 3, 10'(7'h02) << 3);
        set_slot(2, '0, '1);
        set_slot(3, 10'(7'h33) << 3, '0);
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1", "pulse", 8'(match_pulse), 0);
        chk("R1", "gc",    8'(match_gc), 0);
        chk("R1", "slot",  8'(match_slot), 0);
        chk("R1", "rw",    8'(match_rw), 0);
        chk("R1", "flags", 8'(slot_flags), 0);
        rst_n = 1'b1;
        @(negedge clk);
        send(0, 0, 8'h00, 4'h0, 0, 0, 4'h0, 0, 0, "R1_idle");
        send(1, 1, 8'h67, 4'h0, 1, 0, 4'h8, 3, 1, "R2_exact");
        send(1, 1, 8'hA4, 4'h0, 1, 0, 4'h2, 1, 0, "R3_mask");
        send(1, 1, 8'hA1, 4'h0, 1, 0, 4'h3, 0, 1, "R8_multi");
        send(1, 1, 8'hA2, 4'h0, 0, 0, 4'h0, 0, 0, "R3_R4_nomatch");
        send(1, 0, 8'h67, 4'h0, 0, 0, 4'h0, 0, 0, "R10_notfirst");
        send(0, 0, 8'h00, 4'h1, 0, 0, 4'h0, 0, 0, "R9_clear");
        send(1, 1, 8'h67, 4'h8, 1, 0, 4'h8, 3, 1, "R9_setwins");
        gc_en = 1'b1;
        send(1, 1, 8'h00, 4'h0, 1, 1, 4'h0, 0, 0, "R5_gc");
        send(1, 1, 8'h01, 4'h0, 0, 0, 4'h0, 0, 0, "R5_gc_read");
        gc_en = 1'b0;
        send(1, 1, 8'h00, 4'h0, 0, 0, 4'h0, 0, 0, "R5_gc_off");
        // 10-bit setup
        mode10 = 1'b1;
        set_slot(0, 10'h2A5, '0);
        set_slot(1, 10'h1A5, 10'h300);
        set_slot(3, 10'h2A4, '0);
        send(1, 1, 8'hF4, 4'h0, 0, 0, 4'h0, 0, 0, "R6_hdr_only");
        send(1, 0, 8'hA5, 4'h0, 1, 0, 4'h3, 0, 0, "R6_R8_second");
        send(1, 0, 8'hA5, 4'h0, 0, 0, 4'h0, 0, 0, "R6_stray");
        send(1, 1, 8'hF3, 4'h0, 0, 0, 4'h0, 0, 0, "R6_hdr_rd");
        send(1, 0, 8'hA5, 4'h0, 1, 0, 4'h2, 1, 1, "R6_hi_masked");
        send(1, 1, 8'hA8, 4'h0, 0, 0, 4'h0, 0, 0, "R7_nohdr");
        send(0, 0, 8'h00, 4'hF, 0, 0, 4'h0, 0, 0, "R9_clear_all");
        send(0, 0, 8'h00, 4'h0, 0, 0, 4'h0, 0, 0, "R11_hold");
        repeat (3) @(negedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule